// File: doc/BRIEF.md
# Circulant Chaotic System RK4 Stepper

This block advances the three-variable circulant chaotic system by one fourth-order Runge-Kutta step each time it is asked to. Each variable's rate of change is minus itself plus four times the next variable in the ring, minus the cube of that next variable. The ring order is x to y, y to z, and z back to x. One shared combinational evaluator produces the three rates for a given probe vector. A small sequencer presents four probe vectors to it on four consecutive cycles. The four scaled increments are held in registers, and a fifth cycle blends them into the new state.

The state is kept in signed 32-bit fixed point with 24 fraction bits. The block starts at (0.4, 0, 0). The step size is 1/16, applied as an arithmetic right shift by 4. A strobe starts one step. The block then reports a one-cycle completion pulse. It also provides a 16-bit two's-complement view of x that can drive an audio-rate converter.

Top module: `circ_rk4_stepper`

## Requirements
- R1: While reset is held, and until the first step completes, the state reads x = 0x00666666, y = 0, z = 0, and step_done is 0.
- R2: For a probe vector p, the rate of axis i uses n = p[(i+1) mod 3]. It equals (n shifted left by 2) minus p[i] minus the cube of n, in wrapping 32-bit arithmetic. The cube is formed in two steps: first s = (n*n) arithmetically shifted right by 24 and kept to 32 bits, then (s*n) shifted right by 24 in the same way.
- R3: The four probes, in order, are: the state; the state plus k1 shifted right by 1; the state plus k2 shifted right by 1; the state plus k3. Each shift is arithmetic.
- R4: Each increment k equals the rate at its probe, arithmetically shifted right by 4 (dt = 1/16).
- R5: The new value of each axis is the old value plus D. To form D, take S = k1 + 2*k2 + 2*k3 + k4 in 32 bits, multiply it by 2796203 (2^24/6 rounded) at full width, shift the product arithmetically right by 24, and keep 32 bits.
- R6: Call E0 the rising edge at which an idle block samples step_req high. The new state and step_done = 1 both appear after edge E0+5.
- R7: A high step_req at any edge from E0+1 through E0+5 has no effect. It neither restarts nor extends the step, and it adds no extra completion pulse.
- R8: step_done is high for exactly one cycle per step. The state never changes except in the cycle that step_done rises.
- R9: sample equals bits 27 down to 12 of x, which is x in 4.12 format.
- R10: If step_req is held high, steps follow one another with one step every 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-flop synchronizer |
| step_req | input | 1 | Request one integration step; ignored while a step is running |
| state_x | output | 32 | x, signed Q8.24 |
| state_y | output | 32 | y, signed Q8.24 |
| state_z | output | 32 | z, signed Q8.24 |
| step_done | output | 1 | One-cycle pulse when a new state is presented |
| sample | output | 16 | x in two's-complement Q4.12 |

## Verification
A request accepted at one edge produces the updated state and the completion pulse five edges later. The sample output follows the state in the same cycle with no extra register. The two-flop reset synchronizer means the first request can only be accepted from the third edge after reset is released. The bench drives requests on falling edges. A behavioural model in the bench steps forward on every rising edge and is compared with all outputs on every falling edge. Explicit windows count completion pulses under overlapping and held requests.

// File: rtl/circ_rk4_pkg.sv
package circ_rk4_pkg;
  localparam int NDIM      = 3;   // ring of three state variables
  localparam int NSTAGE    = 4;   // RK4 increments
  localparam int FX_W      = 32;
  localparam int FX_FRAC   = 24;
  localparam int DT_SHIFT  = 4;   // dt = 2^-4
  localparam int B_SHIFT   = 2;   // b = 4, a = 1

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_K1   = 3'd1,
    PH_K2   = 3'd2,
    PH_K3   = 3'd3,
    PH_K4   = 3'd4,
    PH_UPD  = 3'd5
  } phase_e;
endpackage

// File: rtl/rk4_ctrl.sv
module rk4_ctrl
  import circ_rk4_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_req,
  output phase_e phase,
  output logic   done
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_IDLE: if (step_req) phase_d = PH_K1;
      PH_K1:   phase_d = PH_K2;
      PH_K2:   phase_d = PH_K3;
      PH_K3:   phase_d = PH_K4;
      PH_K4:   phase_d = PH_UPD;
      PH_UPD:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phase_d;
      done  <= (phase == PH_UPD);
    end
  end
endmodule

// File: rtl/rk4_deriv.sv
module rk4_deriv #(
  parameter int W        = 32,
  parameter int FRAC     = 24,
  parameter int DT_SHIFT = 4,
  parameter int B_SHIFT  = 2,
  parameter int NDIM     = 3
) (
  input  logic signed [W-1:0] probe [NDIM],
  output logic signed [W-1:0] incr  [NDIM]
);
  for (genvar i = 0; i < NDIM; i++) begin : g_axis
    localparam int NX = (i + 1) % NDIM;
    logic signed [2*W-1:0] sq_full, cb_full;
    logic signed [W-1:0]   sq, cb, rate;

    always_comb begin
      sq_full = (2*W)'(probe[NX]) * (2*W)'(probe[NX]);
      sq      = W'(sq_full >>> FRAC);
      cb_full = (2*W)'(sq) * (2*W)'(probe[NX]);
      cb      = W'(cb_full >>> FRAC);
      rate    = (probe[NX] <<< B_SHIFT) - probe[i] - cb;
      incr[i] = rate >>> DT_SHIFT;
    end
  end
endmodule

// File: rtl/rk4_combine.sv
module rk4_combine #(
  parameter int W    = 32,
  parameter int FRAC = 24,
  parameter int NDIM = 3
) (
  input  logic signed [W-1:0] st [NDIM],
  input  logic signed [W-1:0] k1 [NDIM],
  input  logic signed [W-1:0] k2 [NDIM],
  input  logic signed [W-1:0] k3 [NDIM],
  input  logic signed [W-1:0] k4 [NDIM],
  output logic signed [W-1:0] st_nxt [NDIM]
);
  localparam logic signed [W-1:0] RECIP6 = W'(((2 ** FRAC) + 3) / 6);

  for (genvar i = 0; i < NDIM; i++) begin : g_axis
    logic signed [W-1:0]   wsum, delta;
    logic signed [2*W-1:0] prod;

    always_comb begin
      wsum      = k1[i] + (k2[i] <<< 1) + (k3[i] <<< 1) + k4[i];
      prod      = (2*W)'(wsum) * (2*W)'(RECIP6);
      delta     = W'(prod >>> FRAC);
      st_nxt[i] = st[i] + delta;
    end
  end
endmodule

// File: rtl/circ_rk4_stepper.sv
module circ_rk4_stepper
  import circ_rk4_pkg::*;
#(
  parameter int W          = FX_W,
  parameter int FRAC       = FX_FRAC,
  parameter int SAMPLE_W   = 16,
  parameter int SAMPLE_INT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_req,
  output logic signed [W-1:0] state_x,
  output logic signed [W-1:0] state_y,
  output logic signed [W-1:0] state_z,
  output logic                step_done,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int SMP_MSB = FRAC + SAMPLE_INT - 1;
  localparam int SMP_LSB = SMP_MSB - SAMPLE_W + 1;
  localparam logic signed [W-1:0] INIT_X = W'((2 * (2 ** FRAC)) / 5);

  logic [1:0]          rst_sync;
  logic                rst_sync_n;
  phase_e              phase;
  logic [NSTAGE-1:0]   k_en;
  logic                upd_en;
  logic signed [W-1:0] st_q   [NDIM];
  logic signed [W-1:0] st_nxt [NDIM];
  logic signed [W-1:0] probe  [NDIM];
  logic signed [W-1:0] incr   [NDIM];
  logic signed [W-1:0] k_q    [NSTAGE][NDIM];

  // reset: asserted at once, released after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  rk4_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_req (step_req),
    .phase    (phase),
    .done     (step_done)
  );

  always_comb begin
    k_en   = '0;
    upd_en = 1'b0;
    case (phase)
      PH_K1:   k_en = 4'b0001;
      PH_K2:   k_en = 4'b0010;
      PH_K3:   k_en = 4'b0100;
      PH_K4:   k_en = 4'b1000;
      PH_UPD:  upd_en = 1'b1;
      default: ;
    endcase
  end

  // probe selection for the shared evaluator
  always_comb begin
    for (int i = 0; i < NDIM; i++) begin
      case (phase)
        PH_K2:   probe[i] = st_q[i] + (k_q[0][i] >>> 1);
        PH_K3:   probe[i] = st_q[i] + (k_q[1][i] >>> 1);
        PH_K4:   probe[i] = st_q[i] + k_q[2][i];
        default: probe[i] = st_q[i];
      endcase
    end
  end

  rk4_deriv #(
    .W(W), .FRAC(FRAC), .DT_SHIFT(DT_SHIFT), .B_SHIFT(B_SHIFT), .NDIM(NDIM)
  ) u_deriv (
    .probe (probe),
    .incr  (incr)
  );

  rk4_combine #(.W(W), .FRAC(FRAC), .NDIM(NDIM)) u_combine (
    .st     (st_q),
    .k1     (k_q[0]),
    .k2     (k_q[1]),
    .k3     (k_q[2]),
    .k4     (k_q[3]),
    .st_nxt (st_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q[0] <= INIT_X;
      for (int i = 1; i < NDIM; i++) st_q[i] <= '0;
      for (int s = 0; s < NSTAGE; s++)
        for (int i = 0; i < NDIM; i++) k_q[s][i] <= '0;
    end else begin
      for (int s = 0; s < NSTAGE; s++)
        if (k_en[s])
          for (int i = 0; i < NDIM; i++) k_q[s][i] <= incr[i];
      if (upd_en)
        for (int i = 0; i < NDIM; i++) st_q[i] <= st_nxt[i];
    end
  end

  assign state_x = st_q[0];
  assign state_y = st_q[1];
  assign state_z = st_q[2];
  assign sample  = st_q[0][SMP_MSB:SMP_LSB];
endmodule

// File: rtl/circ_rk4_checker.sv
module circ_rk4_checker
  import circ_rk4_pkg::*;
#(
  parameter int W = FX_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input phase_e              phase,
  input logic signed [W-1:0] x
);
  // R8: completion pulse never lasts two cycles
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: completion only follows the blend cycle
  p_done_after_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == PH_UPD));

  // R7: a new step only begins from idle with a request
  p_k1_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_K1) |-> ($past(phase) == PH_IDLE && $past(start)));

  // R3: third probe always follows the second
  p_stage_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_K3) |-> ($past(phase) == PH_K2));

  // R8: state moves only together with the completion pulse
  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (x != $past(x)) |-> done);
endmodule

bind circ_rk4_stepper circ_rk4_checker #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .start (step_req),
  .done  (step_done),
  .phase (phase),
  .x     (state_x)
);

// File: tb/circ_rk4_stepper_test.sv
module circ_rk4_stepper_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_req;
  logic [31:0] state_x, state_y, state_z;
  logic        step_done;
  logic [15:0] sample;

  int total = 0;
  int bad   = 0;

  // behavioural reference
  int mx [3];
  bit m_done;
  int m_ph;
  int m_rcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_rk4_stepper uut (
    .clk(clk), .rst_n(rst_n), .step_req(step_req),
    .state_x(state_x), .state_y(state_y), .state_z(state_z),
    .step_done(step_done), .sample(sample)
  );

  function automatic int rate_inc(int own, int nx);
    longint p;
    int sq, cb, d;
    p  = longint'(nx) * longint'(nx);
    sq = int'(p >>> 24);
    p  = longint'(sq) * longint'(nx);
    cb = int'(p >>> 24);
    d  = 4 * nx - own - cb;
    return d >>> 4;
  endfunction

  task automatic model_step();
    int k [4][3];
    int pr [3];
    int sum;
    longint p;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 3; i++) begin
        if (s == 0)      pr[i] = mx[i];
        else if (s == 3) pr[i] = mx[i] + k[2][i];
        else             pr[i] = mx[i] + (k[s-1][i] >>> 1);
      end
      for (int i = 0; i < 3; i++) k[s][i] = rate_inc(pr[i], pr[(i+1)%3]);
    end
    for (int i = 0; i < 3; i++) begin
      sum   = k[0][i] + 2*k[1][i] + 2*k[2][i] + k[3][i];
      p     = longint'(sum) * 64'sd2796203;
      mx[i] = mx[i] + int'(p >>> 24);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx[0] = 32'h00666666; mx[1] = 0; mx[2] = 0;
      m_done = 0; m_ph = 0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      m_done = (m_ph == 5);
      if (m_ph == 5) begin
        model_step();
        m_ph = 0;
      end else if (m_ph > 0) m_ph++;
      else if (step_req) m_ph = 1;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    logic [31:0] ex;
    ex = mx[0];
    chk(state_x === mx[0], "R2/R3/R4/R5 state_x", state_x, ex);
    chk(state_y === mx[1], "R2/R3/R4/R5 state_y", state_y, mx[1]);
    chk(state_z === mx[2], "R2/R3/R4/R5 state_z", state_z, mx[2]);
    chk(step_done === m_done, "R6 R7 R8 step_done", step_done, m_done);
    chk(sample === ex[27:12], "R9 sample", sample, ex[27:12]);
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int cnt;
    logic [7:0] lfsr;
    rst_n = 1'b0;
    step_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(state_x === 32'h00666666, "R1 x", state_x, 32'h00666666);
    chk(state_y === 32'h0 && state_z === 32'h0, "R1 y,z", {state_y, state_z}, 0);
    chk(step_done === 1'b0, "R1 done", step_done, 0);
    chk(sample === 16'h0666, "R9 reset sample", sample, 16'h0666);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(state_x === 32'h00666666, "R1 idle hold", state_x, 32'h00666666);

    // single step: done due on the 5th negedge after acceptance (R6)
    step_req = 1'b1;
    @(negedge clk) step_req = 1'b0;
    cnt = 0;
    repeat (4) @(negedge clk) if (step_done) cnt++;
    chk(cnt == 0, "R6 early done", cnt, 0);
    @(negedge clk);
    chk(step_done === 1'b1, "R6 done timing", step_done, 1);
    repeat (6) @(negedge clk);

    // R7: requests during a running step are ignored
    step_req = 1'b1;
    @(negedge clk) step_req = 1'b0;
    @(negedge clk) step_req = 1'b1;
    @(negedge clk) step_req = 1'b0;
    @(negedge clk) step_req = 1'b1;
    @(negedge clk) step_req = 1'b0;
    cnt = 0;
    repeat (8) @(negedge clk) if (step_done) cnt++;
    chk(cnt == 1, "R7 single completion", cnt, 1);

    // R10: held request gives one step per 6 cycles
    step_req = 1'b1;
    cnt = 0;
    repeat (60) @(negedge clk) if (step_done) cnt++;
    step_req = 1'b0;
    chk(cnt == 10, "R10 held rate", cnt, 10);
    repeat (8) @(negedge clk);

    // irregular request pattern
    lfsr = 8'hA5;
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step_req = lfsr[0];
    end

    // long held run to let the trajectory develop
    step_req = 1'b1;
    repeat (3000) @(negedge clk);
    step_req = 1'b0;
    repeat (10) @(negedge clk);
    summary();
  end
endmodule